// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block drains a ring of transmit descriptors held in word-wide memory. Software places descriptors in the ring and then moves a produce index forward. While the produce index differs from the consume index, the block reads the descriptor at the consume slot. Each descriptor is two words: a buffer pointer, then a control word. The block reads the bytes that the pointer and length name and presents them one byte per cycle on a valid/ready stream for a MAC transmitter. It then writes a one-word completion entry into a separate status array and moves the consume index forward.

Several descriptors can make up one frame. Their bytes run together on the stream, and the end-of-frame flag rises only on the final byte of the descriptor whose last-fragment bit is set. A descriptor that asks for notification produces a one-cycle interrupt pulse once its status word has been stored. The software side treats the ring as full one slot before the consume index, so one slot always stays empty. Padding, CRC and the MAC itself belong to other blocks.

Top module: `txring_fetcher`

## Requirements
- R1: After reset the produce and consume index registers read 0, and `txValid`, `memReq` and `irqPulse` are low.
- R2: While the produce index equals the consume index, the block issues no memory request and presents no stream data.
- R3: For ring slot `k`, the block reads the pointer word at byte address `descBase + 8*k` and then the control word at `descBase + 8*k + 4`.
- R4: The block streams control bits [10:0] plus one bytes, starting at the pointer's byte address, which may have any alignment. The byte at address `a` sits in bits `[8*(a%4) +: 8]` of the word at `a & ~3`.
- R5: The bytes of consecutive descriptors run together on the stream. `txLast` is high only on the final byte of a descriptor whose control bit 30 is set, and only while `txValid` is high. Control bits 29 to 26 have no effect on this block.
- R6: After the last byte of a descriptor, the block writes its status word to `statBase + 4*k`. Bit 31 of that word is 1, bits [10:0] hold the length minus one, and all other bits are 0.
- R7: The consume index advances by one only when the status write is acknowledged, and it wraps from the ring-size register value (descriptor count minus one) to 0.
- R8: One clock after a status write is acknowledged for a descriptor whose control bit 31 is set, `irqPulse` is high for exactly one cycle. Descriptors without that bit produce no pulse.
- R9: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txLast` hold.
- R10: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until `memAck` is seen.
- R11: Register map on `regAddr`: 0 is the descriptor base, 1 the status base, 2 the ring size (count minus one), 3 the produce index, 4 the consume index. Writes to address 4 are ignored.
- R12: A write to the produce index in the same cycle that the consume index advances takes effect, and that advance also takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Word-aligned byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Memory request completes this cycle |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txLast | output | 1 | Final byte of a frame |
| txReady | input | 1 | Transmitter accepts the byte |
| irqPulse | output | 1 | One-cycle completion interrupt |

## Verification
Software can write the produce index in the same clock edge at which the hardware advances the consume index after the status write is acknowledged. The two updates touch different registers, but a wrong register write path could let one of them mask the other. The bench's memory model lines up this collision exactly: in the cycle it raises the acknowledge for a status write, it also drives a produce-index write. The bench then reads both indices through the register port and requires the old consume value plus one together with the new produce value. It also requires that the descriptor announced by the colliding write is then fetched and streamed.

// File: rtl/txring_pkg.sv
package txring_pkg;

  localparam logic [2:0] REG_DESC_BASE = 3'd0;
  localparam logic [2:0] REG_STAT_BASE = 3'd1;
  localparam logic [2:0] REG_RING_LAST = 3'd2;
  localparam logic [2:0] REG_PROD      = 3'd3;
  localparam logic [2:0] REG_CONS      = 3'd4;

  localparam int CTL_IRQ_BIT  = 31;
  localparam int CTL_LAST_BIT = 30;
  localparam int STAT_DONE_BIT = 31;

  typedef enum logic [1:0] {
    MSEL_PTR,
    MSEL_CTL,
    MSEL_BUF,
    MSEL_STAT
  } memSel_e;

  // strobes from control to datapath
  typedef struct packed {
    memSel_e memSel;
    logic    ldPtr;
    logic    ldCtl;
    logic    ldWord;
    logic    takeByte;
    logic    advCons;
  } dpCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic pending;
    logic wordValid;
    logic finalByte;
    logic fragLast;
    logic wantIrq;
  } dpFlag_t;

endpackage

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  dpCtl_t            ctl,
  output dpFlag_t           flag,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [7:0]        txData,
  output logic [IDX_W-1:0]  consIdx
);

  localparam int LANES      = DATA_W / 8;
  localparam int LANE_W     = $clog2(LANES);
  localparam int DESC_SHIFT = LANE_W + 1;

  logic [ADDR_W-1:0] descBaseQ, statBaseQ, ptrQ, byteAddrQ;
  logic [IDX_W-1:0]  ringLastQ, prodQ, consQ;
  logic [LEN_W-1:0]  lenQ, remainQ;
  logic              fragLastQ, irqReqQ, wordValidQ;
  logic [DATA_W-1:0] wordQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descBaseQ  <= '0;
      statBaseQ  <= '0;
      ringLastQ  <= '0;
      prodQ      <= '0;
      consQ      <= '0;
      ptrQ       <= '0;
      byteAddrQ  <= '0;
      lenQ       <= '0;
      remainQ    <= '0;
      fragLastQ  <= 1'b0;
      irqReqQ    <= 1'b0;
      wordValidQ <= 1'b0;
      wordQ      <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          REG_DESC_BASE: descBaseQ <= regWrData[ADDR_W-1:0];
          REG_STAT_BASE: statBaseQ <= regWrData[ADDR_W-1:0];
          REG_RING_LAST: ringLastQ <= regWrData[IDX_W-1:0];
          REG_PROD:      prodQ     <= regWrData[IDX_W-1:0];
          default: ;
        endcase
      end
      if (ctl.advCons) begin
        consQ <= (consQ == ringLastQ) ? '0 : consQ + 1'b1;
      end
      if (ctl.ldPtr) begin
        ptrQ <= memRdata[ADDR_W-1:0];
      end
      if (ctl.ldCtl) begin
        lenQ       <= memRdata[LEN_W-1:0];
        remainQ    <= memRdata[LEN_W-1:0];
        fragLastQ  <= memRdata[CTL_LAST_BIT];
        irqReqQ    <= memRdata[CTL_IRQ_BIT];
        byteAddrQ  <= ptrQ;
        wordValidQ <= 1'b0;
      end
      if (ctl.ldWord) begin
        wordQ      <= memRdata;
        wordValidQ <= 1'b1;
      end
      if (ctl.takeByte) begin
        byteAddrQ <= byteAddrQ + 1'b1;
        remainQ   <= remainQ - 1'b1;
        if (&byteAddrQ[LANE_W-1:0]) begin
          wordValidQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_DESC_BASE: regRdData[ADDR_W-1:0] = descBaseQ;
      REG_STAT_BASE: regRdData[ADDR_W-1:0] = statBaseQ;
      REG_RING_LAST: regRdData[IDX_W-1:0]  = ringLastQ;
      REG_PROD:      regRdData[IDX_W-1:0]  = prodQ;
      REG_CONS:      regRdData[IDX_W-1:0]  = consQ;
      default: ;
    endcase
  end

  always_comb begin
    case (ctl.memSel)
      MSEL_PTR:  memAddr = descBaseQ + (ADDR_W'(consQ) << DESC_SHIFT);
      MSEL_CTL:  memAddr = descBaseQ + (ADDR_W'(consQ) << DESC_SHIFT) + ADDR_W'(LANES);
      MSEL_BUF:  memAddr = {byteAddrQ[ADDR_W-1:LANE_W], LANE_W'(0)};
      default:   memAddr = statBaseQ + (ADDR_W'(consQ) << LANE_W);
    endcase
  end

  always_comb begin
    memWdata                = '0;
    memWdata[STAT_DONE_BIT] = 1'b1;
    memWdata[LEN_W-1:0]     = lenQ;
  end

  assign txData  = wordQ[8*byteAddrQ[LANE_W-1:0] +: 8];
  assign consIdx = consQ;

  assign flag.pending   = (consQ != prodQ);
  assign flag.wordValid = wordValidQ;
  assign flag.finalByte = (remainQ == '0);
  assign flag.fragLast  = fragLastQ;
  assign flag.wantIrq   = irqReqQ;

endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  dpFlag_t flag,
  input  logic    memAck,
  input  logic    txReady,
  output dpCtl_t  ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    txValid,
  output logic    txLast,
  output logic    irqPulse
);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PTR,
    S_CTL,
    S_DATA,
    S_STAT
  } state_e;

  state_e stQ, stNext;
  logic   irqQ;

  always_comb begin
    ctl     = '0;
    ctl.memSel = MSEL_PTR;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txValid = 1'b0;
    txLast  = 1'b0;
    stNext  = stQ;
    case (stQ)
      S_IDLE: begin
        if (flag.pending) stNext = S_PTR;
      end
      S_PTR: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.ldPtr = 1'b1;
          stNext    = S_CTL;
        end
      end
      S_CTL: begin
        ctl.memSel = MSEL_CTL;
        memReq     = 1'b1;
        if (memAck) begin
          ctl.ldCtl = 1'b1;
          stNext    = S_DATA;
        end
      end
      S_DATA: begin
        if (!flag.wordValid) begin
          ctl.memSel = MSEL_BUF;
          memReq     = 1'b1;
          if (memAck) ctl.ldWord = 1'b1;
        end else begin
          txValid = 1'b1;
          txLast  = flag.finalByte && flag.fragLast;
          if (txReady) begin
            ctl.takeByte = 1'b1;
            if (flag.finalByte) stNext = S_STAT;
          end
        end
      end
      S_STAT: begin
        ctl.memSel = MSEL_STAT;
        memReq     = 1'b1;
        memWe      = 1'b1;
        if (memAck) begin
          ctl.advCons = 1'b1;
          stNext      = S_IDLE;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ  <= S_IDLE;
      irqQ <= 1'b0;
    end else begin
      stQ  <= stNext;
      irqQ <= (stQ == S_STAT) && memAck && flag.wantIrq;
    end
  end

  assign irqPulse = irqQ;

endmodule

// File: rtl/txring_fetcher.sv
module txring_fetcher
  import txring_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady,
  output logic              irqPulse
);

  dpCtl_t           dpCtl;
  dpFlag_t          dpFlag;
  logic [IDX_W-1:0] consIdx;

  txring_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .ctl(dpCtl), .flag(dpFlag),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .txData(txData), .consIdx(consIdx)
  );

  txring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .flag(dpFlag), .memAck(memAck), .txReady(txReady),
    .ctl(dpCtl), .memReq(memReq), .memWe(memWe),
    .txValid(txValid), .txLast(txLast), .irqPulse(irqPulse)
  );

endmodule

// File: rtl/txring_fetcher_chk.sv
module txring_fetcher_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [7:0]        txData,
  input logic              txValid,
  input logic              txLast,
  input logic              txReady,
  input logic              irqPulse,
  input logic [IDX_W-1:0]  consIdx
);

  a_r5_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  a_r9_stream_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  a_r8_irq_after_status: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(memReq && memWe && memAck));

  a_r7_cons_after_status: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(consIdx) |-> $past(memReq && memWe && memAck));

  a_r2_no_stream_while_fetching: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !txValid);

endmodule

bind txring_fetcher txring_fetcher_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .memReq(memReq), .memWe(memWe), .memAck(memAck),
  .memAddr(memAddr), .memWdata(memWdata),
  .txData(txData), .txValid(txValid), .txLast(txLast), .txReady(txReady),
  .irqPulse(irqPulse), .consIdx(consIdx)
);

// File: tb/txring_fetcher_bench.sv
module txring_fetcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DESC_BASE = 32'h100;
  localparam logic [31:0] STAT_BASE = 32'h200;
  localparam logic [31:0] CTL_IRQ   = 32'h8000_0000;
  localparam logic [31:0] CTL_LAST  = 32'h4000_0000;
  localparam logic [31:0] CTL_CRC   = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;
  logic [7:0]  txData;
  logic        txValid, txLast;
  logic        txReady = 1'b1;
  logic        irqPulse;

  txring_fetcher u_txring_fetcher (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck),
    .txData(txData), .txValid(txValid), .txLast(txLast), .txReady(txReady),
    .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int memWait = 0;
  int stallMode = 0;
  int cyc = 0;
  int irqCount = 0;
  int reqCount = 0;
  int waitCnt = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] rdLog[$];
  logic [8:0]  rxQ[$];
  logic [8:0]  expQ[$];
  bit          collideArm = 0;
  bit          collideFired = 0;
  bit          collideClear = 0;
  logic [31:0] collideVal = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and stream sink, both driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (irqPulse) irqCount++;
    if (memReq) reqCount++;
    if (memAck) begin
      memAck = 1'b0;
      if (collideClear) begin
        regWrEn = 1'b0;
        collideClear = 0;
      end
    end else if (memReq && rstN) begin
      if (waitCnt < memWait) waitCnt++;
      else begin
        waitCnt = 0;
        memAck = 1'b1;
        if (memWe) begin
          mem[memAddr[11:2]] = memWdata;
          if (collideArm) begin
            regWrEn = 1'b1;
            regAddr = 3'd3;
            regWrData = collideVal;
            collideArm = 0;
            collideFired = 1;
            collideClear = 1;
          end
        end else begin
          memRdata = mem[memAddr[11:2]];
          rdLog.push_back(memAddr);
        end
      end
    end
    txReady = (stallMode == 0) ? 1'b1 : ((cyc % 5) >= 2);
    if (txValid && txReady) rxQ.push_back({txLast, txData});
  end

  function automatic logic [7:0] getByte(input logic [31:0] a);
    logic [31:0] w;
    w = mem[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic addExp(input logic [31:0] ptr, input int len, input bit lastFrag);
    for (int i = 0; i < len; i++)
      expQ.push_back({(lastFrag && i == len - 1), getByte(ptr + i)});
  endtask

  task automatic setDesc(input int idx, input logic [31:0] ptr, input logic [31:0] ctl);
    mem[(DESC_BASE >> 2) + 2*idx]     = ptr;
    mem[(DESC_BASE >> 2) + 2*idx + 1] = ctl;
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdLog.delete(); rxQ.delete(); expQ.delete();
    irqCount = 0; reqCount = 0; memWait = 0; stallMode = 0;
  endtask

  task automatic setupRing(input logic [31:0] ringLast);
    regWrite(3'd0, DESC_BASE);
    regWrite(3'd1, STAT_BASE);
    regWrite(3'd2, ringLast);
  endtask

  task automatic waitCons(input logic [31:0] target, input string tag);
    logic [31:0] v;
    v = '1;
    for (int i = 0; i < 5000 && v != target; i++) begin
      @(negedge clk);
      regRead(3'd4, v);
    end
    repeat (3) @(negedge clk);
    check(v == target, tag, v, target);
  endtask

  task automatic checkFrame(input string tag);
    check(rxQ.size() == expQ.size(), tag, rxQ.size(), expQ.size());
    for (int i = 0; i < expQ.size() && i < rxQ.size(); i++)
      check(rxQ[i] == expQ[i], tag, {23'd0, rxQ[i]}, {23'd0, expQ[i]});
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    regRead(3'd4, v); check(v == 0, "R1 consume index after reset", v, 0);
    regRead(3'd3, v); check(v == 0, "R1 produce index after reset", v, 0);
    check(!txValid && !memReq && !irqPulse, "R1 outputs idle after reset",
          {txValid, memReq, irqPulse}, 0);
    setupRing(7);
    repeat (20) @(negedge clk);
    check(reqCount == 0, "R2 no fetch while ring empty", reqCount, 0);
    check(rxQ.size() == 0, "R2 no stream while ring empty", rxQ.size(), 0);
  endtask

  task automatic testSingle();
    doReset();
    setupRing(7);
    setDesc(0, 32'h400, CTL_IRQ | CTL_LAST | 32'd5);
    addExp(32'h400, 6, 1);
    regWrite(3'd3, 1);
    waitCons(1, "R7 consume advance single");
    check(rdLog.size() >= 2 && rdLog[0] == DESC_BASE, "R3 pointer word address", rdLog[0], DESC_BASE);
    check(rdLog.size() >= 2 && rdLog[1] == DESC_BASE + 4, "R3 control word address", rdLog[1], DESC_BASE + 4);
    checkFrame("R4 single aligned frame");
    check(mem[STAT_BASE >> 2] == 32'h8000_0005, "R6 status word single", mem[STAT_BASE >> 2], 32'h8000_0005);
    check(irqCount == 1, "R8 one pulse for irq descriptor", irqCount, 1);
  endtask

  task automatic testFragments();
    doReset();
    setupRing(7);
    setDesc(0, 32'h503, CTL_CRC | 32'd6);
    setDesc(1, 32'h611, CTL_LAST | 32'd2);
    addExp(32'h503, 7, 0);
    addExp(32'h611, 3, 1);
    regWrite(3'd3, 2);
    waitCons(2, "R7 consume after two fragments");
    checkFrame("R5 fragments joined, last on final byte");
    check(mem[STAT_BASE >> 2] == 32'h8000_0006, "R6 status fragment 0", mem[STAT_BASE >> 2], 32'h8000_0006);
    check(mem[(STAT_BASE >> 2) + 1] == 32'h8000_0002, "R6 status fragment 1", mem[(STAT_BASE >> 2) + 1], 32'h8000_0002);
    check(irqCount == 0, "R8 no pulse without irq bit", irqCount, 0);
  endtask

  task automatic testBackpressure();
    doReset();
    memWait = 3;
    stallMode = 1;
    setupRing(7);
    setDesc(0, 32'h702, CTL_LAST | 32'd8);
    addExp(32'h702, 9, 1);
    regWrite(3'd3, 1);
    waitCons(1, "R10 consume with slow memory");
    checkFrame("R9 frame intact under stalls");
  endtask

  task automatic testWrap();
    doReset();
    setupRing(3);
    setDesc(0, 32'h400, CTL_LAST | 32'd1);
    setDesc(1, 32'h410, CTL_LAST | 32'd2);
    setDesc(2, 32'h420, CTL_LAST | 32'd3);
    addExp(32'h400, 2, 1); addExp(32'h410, 3, 1); addExp(32'h420, 4, 1);
    regWrite(3'd3, 3);
    waitCons(3, "R7 consume reaches last slot");
    setDesc(3, 32'h431, CTL_LAST | 32'd4);
    setDesc(0, 32'h440, CTL_IRQ | CTL_LAST | 32'd0);
    addExp(32'h431, 5, 1); addExp(32'h440, 1, 1);
    regWrite(3'd3, 1);
    waitCons(1, "R7 consume wraps to zero");
    checkFrame("R7 frames in ring order across wrap");
    check(mem[(STAT_BASE >> 2) + 3] == 32'h8000_0004, "R6 status in last slot", mem[(STAT_BASE >> 2) + 3], 32'h8000_0004);
    check(mem[STAT_BASE >> 2] == 32'h8000_0000, "R6 status after wrap", mem[STAT_BASE >> 2], 32'h8000_0000);
    check(irqCount == 1, "R8 single pulse in wrap run", irqCount, 1);
  endtask

  task automatic testCollision();
    logic [31:0] v;
    doReset();
    setupRing(7);
    setDesc(0, 32'h400, CTL_IRQ | CTL_LAST | 32'd3);
    setDesc(1, 32'h420, CTL_LAST | 32'd4);
    addExp(32'h400, 4, 1); addExp(32'h420, 5, 1);
    collideVal = 2;
    collideFired = 0;
    collideArm = 1;
    regWrite(3'd3, 1);
    for (int i = 0; i < 2000 && !collideFired; i++) @(negedge clk);
    @(negedge clk);
    regRead(3'd4, v); check(v == 1, "R12 consume advance kept", v, 1);
    regRead(3'd3, v); check(v == 2, "R12 produce write kept", v, 2);
    waitCons(2, "R12 new descriptor consumed");
    checkFrame("R12 both frames streamed");
  endtask

  task automatic testConsReadOnly();
    logic [31:0] v;
    doReset();
    setupRing(7);
    regWrite(3'd4, 5);
    repeat (10) @(negedge clk);
    regRead(3'd4, v); check(v == 0, "R11 consume index ignores write", v, 0);
    regRead(3'd2, v); check(v == 7, "R11 ring size readback", v, 7);
    check(reqCount == 0, "R11 ignored write starts no fetch", reqCount, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = i * 32'h9E37_79B1;
    testReset();
    testSingle();
    testFragments();
    testBackpressure();
    testWrap();
    testCollision();
    testConsReadOnly();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule